// File: doc/BRIEF.md
# Link Speed Retrain Sequencer

This block runs once after reset beside a PCIe root port. It decides whether the link has come up at the lowest data rate even though the port could run faster. If it has, the block asks for a retrain and then waits for the retrain to finish and for the link to return to the active state. It reaches the port's link capability, link status and link control registers through a simple request/acknowledge register port. It watches the training state machine's state code to tell whether the link is active.

The check runs in a fixed order. First the block confirms the link is active. Then it reads the supported speed, then the current speed. If a retrain is needed, it reads link control, sets the retrain bit and writes the value back. Two bounded waits follow. The first polls the training-in-progress bit at a fixed interval. The second watches for the link to become active. Each wait has its own cycle budget and its own sticky timeout flag. The second wait always runs, even when the first one ran out of time. When the sequence ends for any reason, `done` rises and stays high until the next reset.

Top module: `link_retrain_seq`

## Requirements
- R1: While reset is held, `done`, `retrain_timeout`, `linkup_timeout` and `reg_req` are all 0.
- R2: The link counts as active only when `ltssm_state` equals 5'h0F. If it is not active when the sequence starts, the block sets `done` and makes no register access.
- R3: The block reads the capability register at `CAP_ADDR`. If its bits [3:0] (supported speed) are 0 or 1, the block makes no further access and sets `done`.
- R4: The block then reads the status register at `STA_ADDR`. If its bits [3:0] (current speed) are not 1, the block makes no further access and sets `done`.
- R5: If a retrain is needed, the block reads the control register at `CTL_ADDR`. It then makes exactly one write, to `CTL_ADDR`, with the value read OR 16'h0020 (bit 5 set and all other bits kept).
- R6: After the write, the block polls the status register until bit 11 reads 0. If bit 11 still reads 1 after `TRAIN_TO` cycles, `retrain_timeout` is set.
- R7: The second wait always follows the first. It ends when the link is active. If the link is still not active after `UP_TO` cycles, `linkup_timeout` is set together with `done`.
- R8: Once `done` is set, it stays set, both flags hold their values, and no further register request is made.
- R9: `reg_req` stays high, with `reg_addr`, `reg_we` and `reg_wdata` unchanged, until the cycle in which `reg_ack` is sampled high. It drops in the following cycle.
- R10: Two consecutive reads of the status register are separated by at least `POLL_GAP` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ltssm_state | input | 5 | Current state code of the link training state machine |
| reg_req | output | 1 | Register access request, held until acknowledged |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | REG_W | Write data |
| reg_ack | input | 1 | One-cycle acknowledge from the register port |
| reg_rdata | input | REG_W | Read data, valid with `reg_ack` |
| done | output | 1 | Sequence finished (sticky) |
| retrain_timeout | output | 1 | Training bit did not clear within `TRAIN_TO` cycles (sticky) |
| linkup_timeout | output | 1 | Link did not become active within `UP_TO` cycles (sticky) |

## Verification
The bench builds the block with `TRAIN_TO` = 60, `UP_TO` = 40 and `POLL_GAP` = 4. With these values each run, including one where both waits run out of time, takes a few hundred cycles. That makes it affordable to sweep every combination of initial link state, supported speed 0..3 and current speed 0..3. It also covers all four outcomes of the two waits, including a link that comes back while the training bit is still stuck. A register model with a fixed acknowledge latency checks the handshake, the polling gaps and the write-back value.

// File: rtl/rt_seq_pkg.sv
package rt_seq_pkg;
    localparam int            LTSSM_W       = 5;
    localparam logic [4:0]    LTSSM_ACTIVE  = 5'h0F;
    localparam int            SPD_W         = 4;
    localparam logic [3:0]    SPD_LOWEST    = 4'd1;
    localparam int            TRAINING_BIT  = 11;
    localparam int            RETRAIN_BIT   = 5;

    typedef enum logic [3:0] {
        S_START,
        S_RD_CAP,
        S_RD_STA,
        S_RD_CTL,
        S_WR_CTL,
        S_POLL,
        S_GAP,
        S_WAIT_UP,
        S_DONE
    } seq_state_e;
endpackage

// File: rtl/rt_cycle_timer.sv
module rt_cycle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (cnt_q != TOP) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/rt_reg_master.sv
module rt_reg_master #(
    parameter int ADDR_W = 12,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              go_we,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic [REG_W-1:0]  go_wdata,
    output logic              reg_req,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_ack,
    input  logic [REG_W-1:0]  reg_rdata,
    output logic              xfer_done,
    output logic [REG_W-1:0]  xfer_rdata
);
    typedef struct packed {
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  wdata;
        logic [REG_W-1:0]  rdata;
        logic              fin;
    } rm_t;

    rm_t cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.fin = 1'b0;
        if (cur_q.req) begin
            if (reg_ack) begin
                nxt_d.req   = 1'b0;
                nxt_d.fin   = 1'b1;
                nxt_d.rdata = reg_rdata;
            end
        end else if (go) begin
            nxt_d.req   = 1'b1;
            nxt_d.we    = go_we;
            nxt_d.addr  = go_addr;
            nxt_d.wdata = go_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign reg_req    = cur_q.req;
    assign reg_we     = cur_q.we;
    assign reg_addr   = cur_q.addr;
    assign reg_wdata  = cur_q.wdata;
    assign xfer_done  = cur_q.fin;
    assign xfer_rdata = cur_q.rdata;
endmodule

// File: rtl/rt_seq_ctrl.sv
module rt_seq_ctrl
    import rt_seq_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter int                REG_W    = 16,
    parameter logic [ADDR_W-1:0] CAP_ADDR = '0,
    parameter logic [ADDR_W-1:0] STA_ADDR = '0,
    parameter logic [ADDR_W-1:0] CTL_ADDR = '0,
    parameter int                TRAIN_TO = 100,
    parameter int                UP_TO    = 100,
    parameter int                POLL_GAP = 4,
    parameter int                TW       = 8,
    parameter int                GW       = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LTSSM_W-1:0] ltssm_state,
    output logic               go,
    output logic               go_we,
    output logic [ADDR_W-1:0]  go_addr,
    output logic [REG_W-1:0]   go_wdata,
    input  logic               xfer_done,
    input  logic [REG_W-1:0]   xfer_rdata,
    input  logic [TW-1:0]      phase_cnt,
    output logic               phase_clr,
    input  logic [GW-1:0]      gap_cnt,
    output logic               gap_clr,
    output logic               done,
    output logic               retrain_timeout,
    output logic               linkup_timeout
);
    localparam logic [TW-1:0] TRAIN_LIM = TW'(TRAIN_TO);
    localparam logic [TW-1:0] UP_LIM    = TW'(UP_TO);
    localparam logic [GW-1:0] GAP_LIM   = GW'(POLL_GAP - 1);

    typedef struct packed {
        seq_state_e       state;
        logic             pend;
        logic [REG_W-1:0] ctl_val;
        logic             trn_to;
        logic             up_to;
        logic             fin;
    } sq_t;

    sq_t cur_q, nxt_d;
    logic link_up;

    assign link_up = (ltssm_state == LTSSM_ACTIVE);

    always_comb begin
        nxt_d     = cur_q;
        go        = 1'b0;
        go_we     = 1'b0;
        go_addr   = CAP_ADDR;
        go_wdata  = cur_q.ctl_val;
        phase_clr = 1'b0;
        gap_clr   = 1'b0;
        case (cur_q.state)
            S_START: begin
                if (link_up) begin
                    nxt_d.state = S_RD_CAP;
                end else begin
                    nxt_d.state = S_DONE;
                    nxt_d.fin   = 1'b1;
                end
            end
            S_RD_CAP: begin
                go_addr = CAP_ADDR;
                if (!cur_q.pend) begin
                    go         = 1'b1;
                    nxt_d.pend = 1'b1;
                end else if (xfer_done) begin
                    nxt_d.pend = 1'b0;
                    if (xfer_rdata[SPD_W-1:0] > SPD_LOWEST) begin
                        nxt_d.state = S_RD_STA;
                    end else begin
                        nxt_d.state = S_DONE;
                        nxt_d.fin   = 1'b1;
                    end
                end
            end
            S_RD_STA: begin
                go_addr = STA_ADDR;
                if (!cur_q.pend) begin
                    go         = 1'b1;
                    nxt_d.pend = 1'b1;
                end else if (xfer_done) begin
                    nxt_d.pend = 1'b0;
                    if (xfer_rdata[SPD_W-1:0] == SPD_LOWEST) begin
                        nxt_d.state = S_RD_CTL;
                    end else begin
                        nxt_d.state = S_DONE;
                        nxt_d.fin   = 1'b1;
                    end
                end
            end
            S_RD_CTL: begin
                go_addr = CTL_ADDR;
                if (!cur_q.pend) begin
                    go         = 1'b1;
                    nxt_d.pend = 1'b1;
                end else if (xfer_done) begin
                    nxt_d.pend    = 1'b0;
                    nxt_d.ctl_val = xfer_rdata;
                    nxt_d.ctl_val[RETRAIN_BIT] = 1'b1;
                    nxt_d.state   = S_WR_CTL;
                end
            end
            S_WR_CTL: begin
                go_addr = CTL_ADDR;
                go_we   = 1'b1;
                if (!cur_q.pend) begin
                    go         = 1'b1;
                    nxt_d.pend = 1'b1;
                end else if (xfer_done) begin
                    nxt_d.pend  = 1'b0;
                    nxt_d.state = S_POLL;
                    phase_clr   = 1'b1;
                end
            end
            S_POLL: begin
                go_addr = STA_ADDR;
                if (!cur_q.pend) begin
                    go         = 1'b1;
                    nxt_d.pend = 1'b1;
                end else if (xfer_done) begin
                    nxt_d.pend = 1'b0;
                    if (!xfer_rdata[TRAINING_BIT]) begin
                        nxt_d.state = S_WAIT_UP;
                        phase_clr   = 1'b1;
                    end else if (phase_cnt >= TRAIN_LIM) begin
                        nxt_d.trn_to = 1'b1;
                        nxt_d.state  = S_WAIT_UP;
                        phase_clr    = 1'b1;
                    end else begin
                        nxt_d.state = S_GAP;
                        gap_clr     = 1'b1;
                    end
                end
            end
            S_GAP: begin
                if (gap_cnt >= GAP_LIM) begin
                    nxt_d.state = S_POLL;
                end
            end
            S_WAIT_UP: begin
                if (link_up) begin
                    nxt_d.state = S_DONE;
                    nxt_d.fin   = 1'b1;
                end else if (phase_cnt >= UP_LIM) begin
                    nxt_d.up_to = 1'b1;
                    nxt_d.state = S_DONE;
                    nxt_d.fin   = 1'b1;
                end
            end
            S_DONE: begin
                nxt_d.fin = 1'b1;
            end
            default: begin
                nxt_d.state = S_DONE;
                nxt_d.fin   = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.state <= S_START;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign done            = cur_q.fin;
    assign retrain_timeout = cur_q.trn_to;
    assign linkup_timeout  = cur_q.up_to;
endmodule

// File: rtl/link_retrain_seq.sv
module link_retrain_seq #(
    parameter int                ADDR_W   = 12,
    parameter int                REG_W    = 16,
    parameter logic [ADDR_W-1:0] CAP_ADDR = 12'h08C,
    parameter logic [ADDR_W-1:0] STA_ADDR = 12'h092,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 12'h090,
    parameter int                TRAIN_TO = 50000,
    parameter int                UP_TO    = 50000,
    parameter int                POLL_GAP = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        ltssm_state,
    output logic              reg_req,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_ack,
    input  logic [REG_W-1:0]  reg_rdata,
    output logic              done,
    output logic              retrain_timeout,
    output logic              linkup_timeout
);
    localparam int MAX_TO = (TRAIN_TO > UP_TO) ? TRAIN_TO : UP_TO;
    localparam int TW     = $clog2(MAX_TO + 2);
    localparam int GW     = (POLL_GAP > 1) ? $clog2(POLL_GAP + 1) : 1;

    logic              go, go_we;
    logic [ADDR_W-1:0] go_addr;
    logic [REG_W-1:0]  go_wdata;
    logic              xfer_done;
    logic [REG_W-1:0]  xfer_rdata;
    logic [TW-1:0]     phase_cnt;
    logic              phase_clr;
    logic [GW-1:0]     gap_cnt;
    logic              gap_clr;

    rt_reg_master #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .go_we      (go_we),
        .go_addr    (go_addr),
        .go_wdata   (go_wdata),
        .reg_req    (reg_req),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_ack    (reg_ack),
        .reg_rdata  (reg_rdata),
        .xfer_done  (xfer_done),
        .xfer_rdata (xfer_rdata)
    );

    rt_cycle_timer #(.W(TW)) u_phase_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (phase_clr),
        .cnt   (phase_cnt)
    );

    rt_cycle_timer #(.W(GW)) u_gap_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (gap_clr),
        .cnt   (gap_cnt)
    );

    rt_seq_ctrl #(
        .ADDR_W   (ADDR_W),
        .REG_W    (REG_W),
        .CAP_ADDR (CAP_ADDR),
        .STA_ADDR (STA_ADDR),
        .CTL_ADDR (CTL_ADDR),
        .TRAIN_TO (TRAIN_TO),
        .UP_TO    (UP_TO),
        .POLL_GAP (POLL_GAP),
        .TW       (TW),
        .GW       (GW)
    ) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .ltssm_state     (ltssm_state),
        .go              (go),
        .go_we           (go_we),
        .go_addr         (go_addr),
        .go_wdata        (go_wdata),
        .xfer_done       (xfer_done),
        .xfer_rdata      (xfer_rdata),
        .phase_cnt       (phase_cnt),
        .phase_clr       (phase_clr),
        .gap_cnt         (gap_cnt),
        .gap_clr         (gap_clr),
        .done            (done),
        .retrain_timeout (retrain_timeout),
        .linkup_timeout  (linkup_timeout)
    );
endmodule

// File: rtl/rt_seq_checker.sv
module rt_seq_checker #(
    parameter int                ADDR_W   = 12,
    parameter int                REG_W    = 16,
    parameter logic [ADDR_W-1:0] CTL_ADDR = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_req,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              reg_ack,
    input logic              done,
    input logic              retrain_timeout,
    input logic              linkup_timeout
);
    // R1: quiet outputs on the first edge out of reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> (!done && !reg_req && !retrain_timeout && !linkup_timeout));

    // R9: request and its fields held until acknowledged
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)));

    // R9: request drops after acknowledge
    a_r9_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_ack) |=> !reg_req);

    // R5: the only write goes to control with the retrain bit set
    a_r5_write_target: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we) |-> (reg_addr == CTL_ADDR && reg_wdata[5]));

    // R8: done and flags are sticky
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable(retrain_timeout) && $stable(linkup_timeout)));

    // R8: no register traffic after done
    a_r8_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !reg_req);

    // R7: link-up timeout ends the sequence in the same cycle
    a_r7_upto_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(linkup_timeout) |-> $rose(done));

    // R6/R7: training timeout rises before the second wait ends
    a_r6_trainto_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(retrain_timeout) |-> !done);
endmodule

bind link_retrain_seq rt_seq_checker #(
    .ADDR_W   (ADDR_W),
    .REG_W    (REG_W),
    .CTL_ADDR (CTL_ADDR)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .reg_req         (reg_req),
    .reg_we          (reg_we),
    .reg_addr        (reg_addr),
    .reg_wdata       (reg_wdata),
    .reg_ack         (reg_ack),
    .done            (done),
    .retrain_timeout (retrain_timeout),
    .linkup_timeout  (linkup_timeout)
);

// File: tb/tb_link_retrain_seq.sv
module tb_link_retrain_seq;
    localparam int          ADDR_W   = 12;
    localparam int          REG_W    = 16;
    localparam logic [11:0] CAP_A    = 12'h08C;
    localparam logic [11:0] STA_A    = 12'h092;
    localparam logic [11:0] CTL_A    = 12'h090;
    localparam int          TRAIN_TO = 60;
    localparam int          UP_TO    = 40;
    localparam int          POLL_GAP = 4;
    localparam int          ACK_LAT  = 2;
    localparam int          NEVER    = 1000000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [4:0]        ltssm_state = 5'h00;
    logic              reg_req, reg_we;
    logic [ADDR_W-1:0] reg_addr;
    logic [REG_W-1:0]  reg_wdata;
    logic              reg_ack = 1'b0;
    logic [REG_W-1:0]  reg_rdata = '0;
    logic              done, retrain_timeout, linkup_timeout;

    link_retrain_seq #(
        .ADDR_W(ADDR_W), .REG_W(REG_W),
        .CAP_ADDR(CAP_A), .STA_ADDR(STA_A), .CTL_ADDR(CTL_A),
        .TRAIN_TO(TRAIN_TO), .UP_TO(UP_TO), .POLL_GAP(POLL_GAP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ltssm_state(ltssm_state),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .done(done), .retrain_timeout(retrain_timeout), .linkup_timeout(linkup_timeout)
    );

    always #10 clk = ~clk;

    int tests = 0, fails = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [15:0] r_cap, r_sta, r_ctl;
    int n_acc, n_wr, n_sta, post_done, hold_err, min_gap, last_sta;
    int train_len, up_len, tcnt;
    bit trig, armed, done_seen;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic responder();
        int lat = 0;
        bit active = 0;
        logic [ADDR_W-1:0] a0;
        logic w0;
        logic [REG_W-1:0] d0;
        forever begin
            @(negedge clk);
            if (reg_ack) begin
                reg_ack = 1'b0;
                active  = 0;
            end else if (rst_n && reg_req) begin
                if (!active) begin
                    active = 1; lat = 0;
                    a0 = reg_addr; w0 = reg_we; d0 = reg_wdata;
                    n_acc++;
                    if (done_seen) post_done++;
                    if (reg_addr == STA_A) begin
                        if (last_sta >= 0 && (cyc - last_sta) < min_gap) min_gap = cyc - last_sta;
                        n_sta++;
                    end
                end else if (reg_addr != a0 || reg_we != w0 || reg_wdata != d0) begin
                    hold_err++;
                end
                lat++;
                if (lat >= ACK_LAT) begin
                    if (w0) begin
                        n_wr++;
                        if (a0 == CTL_A) begin
                            r_ctl = d0;
                            if (d0[5]) begin
                                r_sta[11] = 1'b1;
                                ltssm_state = 5'h0B;
                                trig = 1;
                            end
                        end
                    end else begin
                        reg_rdata = (a0 == CAP_A) ? r_cap : (a0 == STA_A) ? r_sta : r_ctl;
                        if (a0 == STA_A) last_sta = cyc;
                    end
                    reg_ack = 1'b1;
                end
            end
        end
    endtask

    task automatic link_model();
        forever begin
            @(negedge clk);
            if (trig) begin
                trig = 0; armed = 1; tcnt = 0;
            end else if (armed) begin
                tcnt++;
                if (tcnt == train_len) r_sta[11] = 1'b0;
                if (tcnt == up_len) ltssm_state = 5'h0F;
            end
        end
    endtask

    task automatic run(input int sls, input int cls, input bit up0, input int tl, input int ul);
        bit retrain;
        logic [15:0] ctl0;
        int waited;
        @(negedge clk);
        rst_n = 1'b0;
        ctl0  = 16'h0103 ^ 16'(cls << 6);
        r_cap = 16'h3C40 | 16'(sls);
        r_sta = 16'h1000 | 16'(cls << 4) | 16'(cls);
        r_ctl = ctl0;
        ltssm_state = up0 ? 5'h0F : ((sls % 2) ? 5'h1F : 5'h0E);
        train_len = tl; up_len = ul;
        trig = 0; armed = 0; done_seen = 0;
        n_acc = 0; n_wr = 0; n_sta = 0; post_done = 0; hold_err = 0;
        min_gap = NEVER; last_sta = -1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!done && !retrain_timeout && !linkup_timeout && !reg_req, "R1 reset state",
              int'({done, retrain_timeout, linkup_timeout, reg_req}), 0);
        rst_n = 1'b1;
        waited = 0;
        while (!done && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        done_seen = 1;
        retrain = up0 && (sls > 1) && (cls == 1);
        repeat (20) @(negedge clk);
        check(done == 1'b1, "R8 done set and held", int'(done), 1);
        if (!up0)
            check(n_acc == 0, "R2 no access when link inactive", n_acc, 0);
        else if (sls <= 1)
            check(n_acc == 1, "R3 stop after capability read", n_acc, 1);
        else if (cls != 1)
            check(n_acc == 2, "R4 stop after status read", n_acc, 2);
        else
            check(n_acc >= 5, "R5 full access sequence", n_acc, 5);
        check(n_wr == (retrain ? 1 : 0), "R5 write count", n_wr, retrain ? 1 : 0);
        check(r_ctl == (retrain ? (ctl0 | 16'h0020) : ctl0), "R5 control value",
              int'(r_ctl), int'(retrain ? (ctl0 | 16'h0020) : ctl0));
        check(retrain_timeout == (retrain && tl >= NEVER), "R6 training timeout flag",
              int'(retrain_timeout), int'(retrain && tl >= NEVER));
        check(linkup_timeout == (retrain && ul >= NEVER), "R7 link-up timeout flag",
              int'(linkup_timeout), int'(retrain && ul >= NEVER));
        check(post_done == 0, "R8 no access after done", post_done, 0);
        check(hold_err == 0, "R9 request held stable", hold_err, 0);
        if (n_sta >= 2)
            check(min_gap >= POLL_GAP, "R10 poll spacing", min_gap, POLL_GAP);
    endtask

    initial begin
        fork
            responder();
            link_model();
        join_none
        for (int u = 0; u < 2; u++)
            for (int s = 0; s < 4; s++)
                for (int c = 0; c < 4; c++)
                    run(s, c, bit'(u), 12, 30);
        // R6/R7: all four outcomes of the two waits
        run(3, 1, 1'b1, 12, 30);
        run(3, 1, 1'b1, NEVER, 20);
        run(2, 1, 1'b1, 12, NEVER);
        run(4, 1, 1'b1, NEVER, NEVER);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule